// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block keeps a four-bank SDRAM refreshed on schedule and takes it into and out of self refresh. An interval timer, whose period is derived from the system clock frequency, adds one owed refresh to a backlog counter each time it expires. While the backlog is non-zero the block asks the main command sequencer for the command bus. Once the bus is granted it closes every bank with a precharge-all, waits the precharge time, issues AUTO REFRESH, and then keeps the bus for the refresh cycle time so that no other command can reach the device.

When the backlog grows past a postponement limit, the block raises an urgent flag and takes the bus without waiting for a grant. A sleep request follows the same precharge path, but the refresh is issued with clock enable low, which puts the device into self refresh. Clock enable stays low for as long as the request is held. When the request is dropped, clock enable returns high and the block keeps the bus, issuing only NOP, for the self-refresh exit time. The lockout lengths are chosen from the clock frequency: 2/7/7 clocks (precharge, refresh cycle, exit) up to 100 MHz, and 3/9/9 clocks above it.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and just after reset the command pins show NOP, clock enable is high, A10 is low, and bus_req, bus_own and urgent are low.
- R2: The timer period is floor(CLK_MHZ*WINDOW_MS*1000/REFRESH_ROWS) clocks (781 at 100 MHz). With the bus always granted, a window of N periods contains at least N-1 AUTO REFRESH commands, and refreshing resumes after a self-refresh exit.
- R3: bus_req rises one cycle after refresh work becomes owed. A grant sampled while bus_req is high yields precharge-all on the next cycle (cs_n,ras_n,cas_n,we_n = 0,0,1,0 with A10 high). bus_own is high from that cycle on, and bus_req falls in the same cycle.
- R4: AUTO REFRESH (0,0,0,1) appears exactly TRP clocks after the precharge-all (2 at 100 MHz or below, 3 above).
- R5: Counting the refresh cycle as the first, bus_own stays high for exactly TRFC clocks (7 or 9) with only NOP (0,1,1,1) after the refresh.
- R6: The backlog rises by one per timer period and falls by one per AUTO REFRESH. urgent is high while the backlog exceeds POSTPONE_MAX and clears once the backlog has been drained.
- R7: While urgent is high, the precharge-all starts without a grant.
- R8: A sleep request is served by a refresh command with clock enable low. Clock enable then stays low with NOP on the pins while the request is held, the timer is stopped, the backlog is emptied and urgent stays low.
- R9: One cycle after the sleep request falls, clock enable is high. Counting that cycle as the first, bus_own stays high with NOP for TXSR clocks (7 or 9) and then falls.
- R10: If the owed work disappears before a grant arrives (a sleep request withdrawn with an empty backlog), bus_req falls on the next cycle and no command is issued.
- R11: A10 is high only in the precharge-all cycle. Every cycle that carries no scheduler command shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Main sequencer hands over the command bus |
| sleep_req | input | 1 | Level request to hold the device in self refresh |
| bus_req | output | 1 | Scheduler is waiting for the command bus |
| bus_own | output | 1 | Scheduler holds the bus; the sequencer must issue nothing |
| urgent | output | 1 | Backlog beyond the postponement limit; bus is taken |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_a10 | output | 1 | Address bit 10, high selects all banks on precharge |

## Verification
All outputs are registered, so each reaction appears one cycle after the clock edge that samples its cause. bus_req follows owed work by one cycle. Precharge-all follows the sampled grant by one cycle. Refresh follows precharge by TRP cycles, and the bus is released TRFC cycles after the refresh or TXSR cycles after clock enable rises. The bench keeps a behavioural model that advances on each rising edge from the same inputs and compares every output at the following falling edge. Separate monitors count the cycles between precharge and refresh and the length of each ownership window, and check those counts against the lockout constants.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASK,
    ST_PRE_WAIT,
    ST_RFC_WAIT,
    ST_SLEEP,
    ST_WAKE
  } rfsh_state_e;

  // cs_n, ras_n, cas_n, we_n
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = 4'b0111;
  localparam sd_cmd_t CMD_PRE = 4'b0010;
  localparam sd_cmd_t CMD_REF = 4'b0001;

  // Clocks between refreshes, rounded down so the rate never falls short.
  function automatic int unsigned refresh_interval(input int unsigned mhz,
                                                   input int unsigned ms,
                                                   input int unsigned rows);
    return (mhz * ms * 1000) / rows;
  endfunction

  function automatic int unsigned by_grade(input bit fast,
                                           input int unsigned fast_ck,
                                           input int unsigned slow_ck);
    return fast ? fast_ck : slow_ck;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 781,
  localparam int TW = $clog2(INTERVAL)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);

  logic [TW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == TW'(INTERVAL - 1));
  assign tick   = !hold && at_end;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  hold_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt_q == '0));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int PEND_W       = 4,
  parameter int POSTPONE_MAX = 4,
  localparam int PEND_TOP    = (1 << PEND_W) - 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic served,
  input  logic clear,
  output logic pend_nz,
  output logic urgent
);

  logic [PEND_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend_q <= '0;
    end else begin
      case ({tick, served})
        2'b10: if (pend_q != PEND_W'(PEND_TOP)) pend_q <= pend_q + 1'b1;
        2'b01: if (pend_q != '0) pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pend_nz = (pend_q != '0);
  assign urgent  = (pend_q > PEND_W'(POSTPONE_MAX));

  // R6
  backlog_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> (pend_q <= $past(pend_q)));

  // R8
  backlog_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !urgent);

endmodule

// File: rtl/rfsh_cmd_seq.sv
module rfsh_cmd_seq
  import rfsh_pkg::*;
#(
  parameter int TRP_CK  = 2,
  parameter int TRFC_CK = 7,
  parameter int TXSR_CK = 7,
  localparam int LONGEST = (TRFC_CK > TXSR_CK) ? TRFC_CK : TXSR_CK,
  localparam int WW      = $clog2(LONGEST + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pend_nz,
  input  logic    urgent,
  input  logic    bus_grant,
  input  logic    sleep_req,
  output sd_cmd_t cmd_o,
  output logic    a10_o,
  output logic    cke_o,
  output logic    req_o,
  output logic    own_o,
  output logic    served_o,
  output logic    enter_sr_o,
  output logic    dormant_o
);

  rfsh_state_e   st_q;
  logic [WW-1:0] wait_q;
  logic          sleep_go_q;
  sd_cmd_t       cmd_q;
  logic          a10_q, cke_q, req_q, own_q;
  logic          need, fire;

  assign need       = pend_nz || sleep_req;
  assign fire       = (st_q == ST_PRE_WAIT) && (wait_q == '0);
  assign served_o   = fire && !sleep_go_q;
  assign enter_sr_o = fire && sleep_go_q;
  assign dormant_o  = (st_q == ST_SLEEP) || (st_q == ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      wait_q     <= '0;
      sleep_go_q <= 1'b0;
      cmd_q      <= CMD_NOP;
      a10_q      <= 1'b0;
      cke_q      <= 1'b1;
      req_q      <= 1'b0;
      own_q      <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      a10_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (need) begin
            st_q  <= ST_ASK;
            req_q <= 1'b1;
          end
        end
        ST_ASK: begin
          if (!need) begin
            st_q  <= ST_IDLE;
            req_q <= 1'b0;
          end else if (bus_grant || urgent) begin
            cmd_q      <= CMD_PRE;
            a10_q      <= 1'b1;
            req_q      <= 1'b0;
            own_q      <= 1'b1;
            sleep_go_q <= sleep_req;
            wait_q     <= WW'(TRP_CK - 1);
            st_q       <= ST_PRE_WAIT;
          end
        end
        ST_PRE_WAIT: begin
          if (wait_q == '0) begin
            cmd_q <= CMD_REF;
            if (sleep_go_q) begin
              cke_q <= 1'b0;
              st_q  <= ST_SLEEP;
            end else begin
              wait_q <= WW'(TRFC_CK - 1);
              st_q   <= ST_RFC_WAIT;
            end
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_RFC_WAIT, ST_WAKE: begin
          if (wait_q == '0) begin
            own_q <= 1'b0;
            st_q  <= ST_IDLE;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_SLEEP: begin
          if (!sleep_req) begin
            cke_q  <= 1'b1;
            wait_q <= WW'(TXSR_CK - 1);
            st_q   <= ST_WAKE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o = cmd_q;
  assign a10_o = a10_q;
  assign cke_o = cke_q;
  assign req_o = req_q;
  assign own_o = own_q;

  // R11
  a10_with_pre_chk: assert property (@(posedge clk) disable iff (rst)
    a10_q |-> (cmd_q == CMD_PRE));

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cke_q && $past(!cke_q)) |-> (cmd_q == CMD_NOP));

  // R9
  wake_owned_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> own_q);

  // R5
  refresh_owned_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd_q == CMD_REF) && cke_q) |=> own_q);

  // R3
  req_own_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_q && own_q));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter int CLK_MHZ        = 100,
  parameter int REFRESH_ROWS   = 8192,
  parameter int WINDOW_MS      = 64,
  parameter int FAST_ABOVE_MHZ = 100,
  parameter int POSTPONE_MAX   = 4,
  parameter int PEND_W         = 4,
  localparam bit FAST    = (CLK_MHZ > FAST_ABOVE_MHZ),
  localparam int INTERVAL = int'(refresh_interval(CLK_MHZ, WINDOW_MS, REFRESH_ROWS)),
  localparam int TRP_CK  = int'(by_grade(FAST, 3, 2)),
  localparam int TRFC_CK = int'(by_grade(FAST, 9, 7)),
  localparam int TXSR_CK = int'(by_grade(FAST, 9, 7))
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_grant,
  input  logic sleep_req,
  output logic bus_req,
  output logic bus_own,
  output logic urgent,
  output logic sd_cke,
  output logic sd_cs_n,
  output logic sd_ras_n,
  output logic sd_cas_n,
  output logic sd_we_n,
  output logic sd_a10
);

  logic    tick, served, enter_sr, dormant, pend_nz;
  sd_cmd_t cmd;

  rfsh_interval_timer #(.INTERVAL(INTERVAL)) timer_i (
    .clk (clk),
    .rst (rst),
    .hold(dormant),
    .tick(tick)
  );

  rfsh_backlog #(.PEND_W(PEND_W), .POSTPONE_MAX(POSTPONE_MAX)) backlog_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .served (served),
    .clear  (enter_sr),
    .pend_nz(pend_nz),
    .urgent (urgent)
  );

  rfsh_cmd_seq #(.TRP_CK(TRP_CK), .TRFC_CK(TRFC_CK), .TXSR_CK(TXSR_CK)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .pend_nz   (pend_nz),
    .urgent    (urgent),
    .bus_grant (bus_grant),
    .sleep_req (sleep_req),
    .cmd_o     (cmd),
    .a10_o     (sd_a10),
    .cke_o     (sd_cke),
    .req_o     (bus_req),
    .own_o     (bus_own),
    .served_o  (served),
    .enter_sr_o(enter_sr),
    .dormant_o (dormant)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

  // R7
  urgent_takes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (urgent && bus_req && !sleep_req) |=> bus_own);

endmodule

// File: tb/sdram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb_top;

  localparam int INTERVAL = (100 * 64 * 1000) / 8192;
  localparam int TRP = 2, TRFC = 7, TXSR = 7, LIMIT = 4, PTOP = 15;
  localparam int NOPC = 7, PREC = 2, REFC = 1;
  localparam int P_IDLE = 0, P_ASK = 1, P_PRE = 2, P_RFC = 3, P_SLP = 4, P_WAKE = 5;

  logic clk = 1'b0, rst = 1'b1, bus_grant = 1'b0, sleep_req = 1'b0;
  logic bus_req, bus_own, urgent, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;

  always #2 clk = ~clk;

  sdram_refresh_sched dut_i (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .sleep_req(sleep_req),
    .bus_req(bus_req), .bus_own(bus_own), .urgent(urgent), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_a10(sd_a10)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  int m_tmr, m_pend, m_ph, m_wait, m_sleepgo, m_grant_edge;
  int e_cmd, e_cke, e_req, e_own;

  always @(posedge clk) begin
    if (rst) begin
      m_tmr = 0; m_pend = 0; m_ph = P_IDLE; m_wait = 0; m_sleepgo = 0;
      e_cmd = NOPC; e_cke = 1; e_req = 0; e_own = 0; m_grant_edge = 0;
    end else begin
      automatic bit asleep = (m_ph == P_SLP) || (m_ph == P_WAKE);
      automatic int due = (!asleep && m_tmr == INTERVAL - 1) ? 1 : 0;
      automatic bit owed = (m_pend > 0) || sleep_req;
      automatic bit hurry = (m_pend > LIMIT);
      automatic int done = 0;
      automatic bit wipe = 0;
      m_grant_edge = bus_grant;
      m_tmr = (asleep || due == 1) ? 0 : m_tmr + 1;
      e_cmd = NOPC;
      if (m_ph == P_IDLE) begin
        if (owed) begin m_ph = P_ASK; e_req = 1; end
      end else if (m_ph == P_ASK) begin
        if (!owed) begin m_ph = P_IDLE; e_req = 0; end
        else if (bus_grant || hurry) begin
          e_cmd = PREC; e_req = 0; e_own = 1; m_ph = P_PRE;
          m_wait = TRP - 1; m_sleepgo = sleep_req;
        end
      end else if (m_ph == P_PRE) begin
        if (m_wait == 0) begin
          e_cmd = REFC;
          if (m_sleepgo != 0) begin e_cke = 0; m_ph = P_SLP; wipe = 1; end
          else begin m_ph = P_RFC; m_wait = TRFC - 1; done = 1; end
        end else m_wait--;
      end else if (m_ph == P_SLP) begin
        if (!sleep_req) begin e_cke = 1; m_ph = P_WAKE; m_wait = TXSR - 1; end
      end else begin
        if (m_wait == 0) begin m_ph = P_IDLE; e_own = 0; end
        else m_wait--;
      end
      if (wipe) m_pend = 0;
      else begin
        m_pend = m_pend + due - done;
        if (m_pend > PTOP) m_pend = PTOP;
        if (m_pend < 0) m_pend = 0;
      end
    end
  end

  // comparison and lockout monitors on the falling edge
  int cyc = 0, last_pre = -100, ref_count = 0, sleep_refs = 0, sr_entries = 0;
  int rfc_len = 0, wake_len = 0, wake_checked = 0;
  bit track_rfc = 0, track_wake = 0, prev_cke = 1, urgent_seen = 0, forced_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      automatic int cmdv = {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      cyc++;
      chk(cmdv == e_cmd, "R4/R5 command pins", cmdv, e_cmd);
      chk(sd_a10 == (e_cmd == PREC), "R11 a10", sd_a10, int'(e_cmd == PREC));
      chk(sd_cke == e_cke, "R8/R9 cke", sd_cke, e_cke);
      chk(bus_req == e_req, "R3/R10 bus_req", bus_req, e_req);
      chk(bus_own == e_own, "R3/R5 bus_own", bus_own, e_own);
      chk(urgent == (m_pend > LIMIT), "R6 urgent", urgent, int'(m_pend > LIMIT));
      if (urgent) urgent_seen = 1;
      if (cmdv == PREC) begin
        last_pre = cyc;
        if (m_grant_edge == 0) forced_seen = 1;
      end
      if (cmdv == REFC) begin
        chk(cyc - last_pre == TRP, "R4 precharge to refresh gap", cyc - last_pre, TRP);
        if (sd_cke) begin
          ref_count++; sleep_refs++; track_rfc = 1; rfc_len = 1;
        end else sr_entries++;
      end else if (track_rfc) begin
        if (bus_own) rfc_len++;
        else begin
          chk(rfc_len == TRFC, "R5 refresh lockout length", rfc_len, TRFC);
          track_rfc = 0;
        end
      end
      if (sd_cke && !prev_cke) begin
        track_wake = 1; wake_len = 1;
      end else if (track_wake) begin
        if (bus_own) wake_len++;
        else begin
          chk(wake_len == TXSR, "R9 exit lockout length", wake_len, TXSR);
          track_wake = 0; wake_checked++;
        end
      end
      prev_cke = sd_cke;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, NOPC);
    chk(sd_cke && !sd_a10, "R1 reset cke/a10", {sd_cke, sd_a10}, 2);
    chk(!bus_req && !bus_own && !urgent, "R1 reset flags", {bus_req, bus_own, urgent}, 0);
    @(posedge clk); #1;
    rst = 1'b0; bus_grant = 1'b1;

    // steady refreshing with the bus always granted
    ref_count = 0;
    repeat (8 * INTERVAL) @(posedge clk);
    #1 chk(ref_count >= 7, "R2 refresh count over 8 periods", ref_count, 7);

    // grant withheld: backlog grows until the bus is taken
    bus_grant = 1'b0; urgent_seen = 0; forced_seen = 0;
    repeat (6 * INTERVAL + 40) @(posedge clk);
    #1 chk(urgent_seen, "R6 urgent raised", urgent_seen, 1);
    chk(forced_seen, "R7 precharge without grant", forced_seen, 1);
    bus_grant = 1'b1;
    repeat (100) @(posedge clk);
    #1 chk(!urgent, "R6 urgent clears after drain", urgent, 0);

    // withdrawn sleep request before any grant
    bus_grant = 1'b0; sleep_req = 1'b1;
    @(posedge clk); #1 sleep_req = 1'b0;
    repeat (10) @(posedge clk);
    #1 chk(!bus_req || urgent, "R10 request withdrawn", bus_req, 0);
    bus_grant = 1'b1;

    // self refresh
    sr_entries = 0; sleep_req = 1'b1;
    repeat (50) @(posedge clk);
    #1 sleep_refs = 0;
    repeat (3000) @(posedge clk);
    #1 chk(!sd_cke, "R8 cke held low", sd_cke, 0);
    chk(sleep_refs == 0, "R8 no auto refresh while asleep", sleep_refs, 0);
    chk(sr_entries == 1, "R8 one self-refresh entry", sr_entries, 1);
    chk(!urgent && !bus_req, "R8 backlog empty while asleep", {urgent, bus_req}, 0);
    wake_checked = 0; sleep_req = 1'b0;
    repeat (40) @(posedge clk);
    #1 chk(sd_cke, "R9 cke restored", sd_cke, 1);
    chk(wake_checked == 1, "R9 exit window measured", wake_checked, 1);

    // refreshing resumes
    ref_count = 0;
    repeat (2 * INTERVAL + 20) @(posedge clk);
    #1 chk(ref_count >= 1, "R2 refresh resumes after wake", ref_count, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule